// File: doc/BRIEF.md
# Strap-Captured Debug Test-Point Multiplexer

This block owns an eight-pin debug test-point port. Just after power-up or a system reset, the low four pins act as inputs. External pulldowns hold them low, and an optional pullup jumper can raise any of them. After a fixed delay the block reads these four straps once and stores them as a mode code. It then turns all eight pins into outputs, and the stored code selects what each pin carries.

Three modes exist. The quiet mode (code 0000, the value that unstrapped pins give) drives every pin low with no toggling. A clock-observation mode routes six internal clocks to the middle pins and holds the two end pins high. A calibration mode shows frame and colour-wheel timing markers and three reset-sequence auxiliary bits. A code that maps to none of these behaves like the quiet mode. The stored code stays in place until power-good drops or a system reset is asserted. Either event restarts the whole sequence.

Top module: `dbg_testpoint_mux`

## Requirements
- R1: With `pwr_good_i` high and `sys_rst_i` low, the straps are captured on the CAPTURE_CYCLES-th rising clock edge after release. CAPTURE_CYCLES equals CLK_MHZ*DELAY_NS/1000, which is 75 at the defaults. `tp_oe_o` becomes all ones one edge later, on edge CAPTURE_CYCLES+1.
- R2: Until the enables assert, `tp_oe_o` and `tp_o` are all zero. This covers the interval after `rst_ni` is asserted.
- R3: A clock edge that samples `pwr_good_i` low or `sys_rst_i` high clears the enables, the outputs and the stored code. It also restarts the delay count from zero.
- R4: Code 0000 drives all eight outputs low with the enables set, whatever the internal clocks and markers do.
- R5: Code 0101 (strap_i[3:0]) sets `tp_o[0]` and `tp_o[7]` to 1 and sets `tp_o[6:1]` to `dbg_clk_i[5:0]`.
- R6: Code 1000 sets `tp_o` to {aux_i[2:0], rev_i, spoke_i, seq_idx_i, dly_idx_i, vsync_i}, with vsync_i on bit 0.
- R7: Any other code drives all outputs low with the enables set.
- R8: A strap change after capture has no effect on `tp_o` until the next reset event.
- R9: The straps pass through two synchroniser flops before capture. A strap change needs at least three edges before the capture edge to be stored. A change made after edge CAPTURE_CYCLES-2 is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Power good, synchronous to clk_i |
| sys_rst_i | input | 1 | System reset, active high, synchronous |
| strap_i | input | 4 | Pad input values of test pins 3:0 |
| dbg_clk_i | input | 6 | Internal clocks shown in clock mode |
| vsync_i | input | 1 | Vertical sync marker |
| dly_idx_i | input | 1 | Delayed wheel index |
| seq_idx_i | input | 1 | Sequence index |
| spoke_i | input | 1 | Wheel spoke marker |
| rev_i | input | 1 | Wheel revolution marker |
| aux_i | input | 3 | Reset-sequence auxiliary bits |
| tp_o | output | 8 | Test-point pad output values |
| tp_oe_o | output | 8 | Per-pin output enables |

## Verification
A delay counter that is off by one shifts the rise of the enables by one edge. That shift shows exactly at edge CAPTURE_CYCLES+1. A wrong synchroniser depth moves the strap window that R9 probes by one edge, and the wrong mode then shows in the first cycle of output. A wrong mode decode or pin order corrupts `tp_o` as soon as the enables rise. A stored code that is not held, or not cleared, shows after the straps are changed or on the first edge of a reset event.

// File: rtl/dbg_tp_pkg.sv
package dbg_tp_pkg;
  localparam int unsigned TP_W   = 8;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned DCLK_W = 6;
  localparam int unsigned AUX_W  = 3;

  localparam logic [CODE_W-1:0] CODE_QUIET = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_CLK   = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_CAL   = 4'b1000;

  typedef enum logic [1:0] {
    MODE_QUIET = 2'd0,
    MODE_CLK   = 2'd1,
    MODE_CAL   = 2'd2
  } tp_mode_e;

  function automatic tp_mode_e decode_mode(input logic [CODE_W-1:0] code);
    unique case (code)
      CODE_CLK: decode_mode = MODE_CLK;
      CODE_CAL: decode_mode = MODE_CAL;
      default:  decode_mode = MODE_QUIET;
    endcase
  endfunction
endpackage

// File: rtl/tp_strap_sync.sv
module tp_strap_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tp_capture_ctrl.sv
module tp_capture_ctrl #(
  parameter int unsigned CODE_W         = 4,
  parameter int unsigned CAPTURE_CYCLES = 75
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [CODE_W-1:0] strap_i,
  output logic [CODE_W-1:0] code_o,
  output logic              oe_o
);
  localparam int unsigned CNT_W = $clog2(CAPTURE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAPTURE_CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              oe_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      code_q <= '0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      code_q <= '0;
    end else if (!done_q) begin
      if (cnt_q == CNT_LAST) begin
        done_q <= 1'b1;
        code_q <= strap_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // enables follow capture by one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     oe_q <= 1'b0;
    else if (hold_i) oe_q <= 1'b0;
    else             oe_q <= done_q;
  end

  assign code_o = code_q;
  assign oe_o   = oe_q;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  a_r1_oe_after_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(done_q));
  a_r2_no_oe_before_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> !oe_q);
  a_r8_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !hold_i) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/tp_out_mux.sv
module tp_out_mux
  import dbg_tp_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  input  logic [DCLK_W-1:0] dbg_clk_i,
  input  logic [TP_W-1:0]   cal_i,
  output logic [TP_W-1:0]   tp_o
);
  tp_mode_e mode;
  assign mode = decode_mode(code_i);

  for (genvar p = 0; p < TP_W; p++) begin : g_pin
    logic clk_src;
    if (p == 0 || p == TP_W - 1) begin : g_rail
      assign clk_src = 1'b1;
    end else begin : g_clk
      assign clk_src = dbg_clk_i[p-1];
    end

    always_comb begin
      tp_o[p] = 1'b0;
      if (en_i) begin
        unique case (mode)
          MODE_CLK: tp_o[p] = clk_src;
          MODE_CAL: tp_o[p] = cal_i[p];
          default:  tp_o[p] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_testpoint_mux.sv
module dbg_testpoint_mux
  import dbg_tp_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned DELAY_NS = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              sys_rst_i,
  input  logic [CODE_W-1:0] strap_i,
  input  logic [DCLK_W-1:0] dbg_clk_i,
  input  logic              vsync_i,
  input  logic              dly_idx_i,
  input  logic              seq_idx_i,
  input  logic              spoke_i,
  input  logic              rev_i,
  input  logic [AUX_W-1:0]  aux_i,
  output logic [TP_W-1:0]   tp_o,
  output logic [TP_W-1:0]   tp_oe_o
);
  localparam int unsigned CAPTURE_CYCLES = (CLK_MHZ * DELAY_NS) / 1000;

  logic              hold;
  logic [CODE_W-1:0] strap_sync;
  logic [CODE_W-1:0] code;
  logic              oe;
  logic [TP_W-1:0]   cal_bus;

  assign hold    = !pwr_good_i || sys_rst_i;
  assign cal_bus = {aux_i, rev_i, spoke_i, seq_idx_i, dly_idx_i, vsync_i};

  tp_strap_sync #(.WIDTH(CODE_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strap_i),
    .q_o   (strap_sync)
  );

  tp_capture_ctrl #(.CODE_W(CODE_W), .CAPTURE_CYCLES(CAPTURE_CYCLES)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .strap_i(strap_sync),
    .code_o (code),
    .oe_o   (oe)
  );

  tp_out_mux u_mux (
    .code_i   (code),
    .en_i     (oe),
    .dbg_clk_i(dbg_clk_i),
    .cal_i    (cal_bus),
    .tp_o     (tp_o)
  );

  assign tp_oe_o = {TP_W{oe}};

  a_r3_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (tp_oe_o == '0 && tp_o == '0));
  a_r5_clk_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_oe_o[0] && code == CODE_CLK) |-> (tp_o[0] && tp_o[TP_W-1]));
  a_r7_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != CODE_CLK && code != CODE_CAL) |-> (tp_o == '0));
endmodule

// File: tb/dbg_testpoint_mux_tb.sv
module dbg_testpoint_mux_tb;
  localparam int DLY = 75; // 50 MHz * 1.5 us

  typedef struct packed {
    logic [3:0] strap;
    logic [5:0] dclk;
    logic [7:0] cal;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0000, 6'h3F, 8'hFF, 8'h00},
    '{4'b0101, 6'h2A, 8'h00, 8'hD5},
    '{4'b0101, 6'h15, 8'hFF, 8'hAB},
    '{4'b1000, 6'h3F, 8'hA5, 8'hA5},
    '{4'b1000, 6'h00, 8'h5A, 8'h5A},
    '{4'b1111, 6'h3F, 8'hFF, 8'h00},
    '{4'b0100, 6'h3F, 8'hFF, 8'h00},
    '{4'b1101, 6'h2A, 8'hA5, 8'h00}
  };

  logic       clk = 0, rst_ni = 0, pwr_good = 0, sys_rst = 0;
  logic [3:0] strap = '0;
  logic [5:0] dclk = '0;
  logic [7:0] cal = '0;
  logic [7:0] tp, tp_oe;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  dbg_testpoint_mux u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good), .sys_rst_i(sys_rst),
    .strap_i(strap), .dbg_clk_i(dclk), .vsync_i(cal[0]), .dly_idx_i(cal[1]),
    .seq_idx_i(cal[2]), .spoke_i(cal[3]), .rev_i(cal[4]), .aux_i(cal[7:5]),
    .tp_o(tp), .tp_oe_o(tp_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // hold in system reset with given straps, release, stop at negedge after edge n
  task automatic restart(logic [3:0] code, int n);
    @(negedge clk);
    strap = code; sys_rst = 1; pwr_good = 1;
    edges(4);
    sys_rst = 0;
    edges(n);
  endtask

  initial begin
    #35;
    chk("R2 reset oe", tp_oe, 8'h00);
    chk("R2 reset tp", tp, 8'h00);
    rst_ni = 1;

    foreach (VECS[k]) begin
      restart(VECS[k].strap, DLY + 1);
      dclk = VECS[k].dclk; cal = VECS[k].cal;
      #1;
      chk("R1 oe up", tp_oe, 8'hFF);
      chk("R4 R5 R6 R7 vector", tp, VECS[k].exp);
    end

    // R1/R2 boundary: not yet enabled after DLY edges
    dclk = 6'h3F; cal = 8'hFF;
    restart(4'b0101, DLY);
    chk("R1 R2 oe low at DLY", tp_oe, 8'h00);
    chk("R2 tp low at DLY", tp, 8'h00);
    edges(1);
    chk("R1 oe at DLY+1", tp_oe, 8'hFF);
    chk("R5 tp at DLY+1", tp, 8'hFF);

    // R8: strap change ignored after capture
    strap = 4'b1000; cal = 8'h00;
    edges(10);
    chk("R8 strap ignored", tp, 8'hFF);

    // R3: power-good drop clears on next edge
    pwr_good = 0;
    edges(1);
    chk("R3 oe cleared", tp_oe, 8'h00);
    chk("R3 tp cleared", tp, 8'h00);
    // restart counts from zero after release
    strap = 4'b0101;
    edges(3);
    pwr_good = 1;
    edges(DLY);
    chk("R3 restart count", tp_oe, 8'h00);
    edges(1);
    chk("R3 restart oe", tp_oe, 8'hFF);
    chk("R3 restart mode", tp, 8'hFF);

    // R3: sys reset mid-operation
    sys_rst = 1;
    edges(1);
    chk("R3 sys_rst clears", tp_oe, 8'h00);
    sys_rst = 0;

    // R9: change between edge DLY-3 and DLY-2 -> captured
    restart(4'b0000, DLY - 3);
    strap = 4'b0101;
    edges(4);
    chk("R9 early change captured", tp, 8'hFF);
    // R9: change between edge DLY-2 and DLY-1 -> not captured
    restart(4'b0000, DLY - 2);
    strap = 4'b0101;
    edges(3);
    chk("R9 late change ignored oe", tp_oe, 8'hFF);
    chk("R9 late change ignored", tp, 8'h00);

    // R2: async reset clears everything
    #3 rst_ni = 0;
    #1;
    chk("R2 async reset oe", tp_oe, 8'h00);
    chk("R2 async reset tp", tp, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule